// File: doc/BRIEF.md
# Pixel store-attribute write unit

This unit sits between a data register's store path and memory. When the register is bound to an attribute slot and store attributes are on, each 32-bit pixel written out is rewritten on the way. The colour bytes can be reordered, the write can be gated by the pixel's alpha against a threshold, and the new pixel can be combined with the word already at the destination by one of several merge operations.

The slot holds a 32-bit control word and a 32-bit mask. Each is loaded in two 16-bit halves through a small configuration port. A 3-bit enable register switches store attributes on and gives the load-side controls as plain outputs. A store that merges with memory first reads the destination word and then writes the merged result. Any other store writes in one cycle. A busy flag holds off the next store request until the current one has finished.

Top module: `pxa_store_attr`

## Requirements
- R1: After reset the control word, the mask and the enables are zero. Writing a low half (cfg_sel 0 for control, 2 for mask) loads bits [15:0] and clears bits [31:16]. Writing a high half (cfg_sel 1 for control, 3 for mask) loads bits [31:16] and keeps bits [15:0].
- R2: Enable bit 0 turns store attributes on. Bit 1 drives ld_attr_en and bit 2 drives ld_invert.
- R3: With store attributes off, a store writes st_data unchanged with all four byte enables set, issues no read, reports no error and completes one cycle after acceptance.
- R4: Control bits [9:8] select the lane order. Code 0 keeps it. Codes 1 and 2 both reverse the four bytes (code 2 undoes code 1). Code 3 keeps the order and raises st_err bit 0.
- R5: The source alpha is byte [31:24] of st_data before any reordering. A store writes only if that alpha is greater than the threshold in control bits [23:16]. Otherwise no memory access takes place, but st_done still pulses.
- R6: When control bit 3 is set, the alpha test is inverted: the store writes only when the alpha is zero.
- R7: When control bit 5 is clear, byte enable 3 (the destination alpha lane [31:24]) is dropped, giving mem_wr_be = 0111.
- R8: When control bit 11 is set, the merge operation in bits [15:12] combines the reordered pixel P with the old word O read from memory, using mask M. The codes are: 0 gives P; 1 and 6 give (O & ~M) | (P & M); 2 gives O ^ P; 3 gives O | P; 4 gives O + P; 5 gives O - P (both wrapping).
- R9: When control bit 11 is clear, the merge operation has no effect: the reordered pixel is written and no read is issued.
- R10: Merge codes 7 to 15 write the reordered pixel and raise st_err bit 0.
- R11: A non-zero width field in control bits [7:6] raises st_err bit 1. The store is still performed as a 32-bit store.
- R12: A merging store reads in the first cycle after acceptance and writes in the second, with st_done in that second cycle. st_busy is high from acceptance until st_done, and st_req is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load one half of control or mask |
| cfg_sel | input | 2 | bit1: mask/control, bit0: high/low half |
| cfg_data | input | 16 | Half-word to load |
| en_wr | input | 1 | Load enable register |
| en_data | input | 3 | Enable bits |
| ld_attr_en | output | 1 | Load attributes on |
| ld_invert | output | 1 | Invert on load |
| st_req | input | 1 | Store request |
| st_addr | input | AW | Store word address |
| st_data | input | 32 | Pixel to store |
| st_busy | output | 1 | Store in progress |
| st_done | output | 1 | Final cycle of a store |
| st_err | output | 2 | bit0 reserved code, bit1 unsupported width; valid with st_done |
| mem_rd_req | output | 1 | Destination read |
| mem_rd_addr | output | AW | Read address |
| mem_rd_data | input | 32 | Read data, valid the cycle after mem_rd_req |
| mem_wr_req | output | 1 | Memory write |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_be | output | 4 | Byte enables |

## Verification
The assertions assume that memory returns read data exactly one cycle after mem_rd_req, with no wait states. They also assume that st_req is a level the requester may hold while busy, with no other handshake. The bench models memory as a synchronous array that answers on the next edge. It issues every store from the idle state, except in one directed case where st_req is deliberately driven while the unit is busy, to check that the request is ignored.

// File: rtl/pxa_pkg.sv
`timescale 1ns/1ps
package pxa_pkg;
    localparam int PIX_W  = 32;
    localparam int LANES  = PIX_W / 8;
    localparam int CW     = 32;
    localparam int HALF_W = CW / 2;
    localparam int EN_W   = 3;

    localparam int EN_STORE = 0;
    localparam int EN_LOAD  = 1;
    localparam int EN_LDINV = 2;

    localparam logic [1:0] SWZ_NONE  = 2'd0;
    localparam logic [1:0] SWZ_REV   = 2'd1;
    localparam logic [1:0] SWZ_UNREV = 2'd2;
    localparam logic [1:0] SWZ_RSV   = 2'd3;

    // Slot control word, MSB first
    typedef struct packed {
        logic [3:0] ext_rsv;
        logic [3:0] fmt_tag;
        logic [7:0] a_thr;
        logic [3:0] mrg_op;
        logic       rd_merge;
        logic       a_src;
        logic [1:0] lane_perm;
        logic [1:0] px_width;
        logic       alpha_wr;
        logic [4:0] flags;
    } attr_ctrl_t;

    typedef enum logic [3:0] {
        MRG_PLAIN = 4'd0,
        MRG_MASK  = 4'd1,
        MRG_XOR   = 4'd2,
        MRG_OR    = 4'd3,
        MRG_ADD   = 4'd4,
        MRG_SUB   = 4'd5,
        MRG_AKEY  = 4'd6
    } merge_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_MERGE,
        ST_WRITE
    } seq_e;

    function automatic logic [PIX_W-1:0] reverse_lanes(input logic [PIX_W-1:0] d);
        logic [PIX_W-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            r[i*8 +: 8] = d[(LANES-1-i)*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic alpha_pass(input attr_ctrl_t c, input logic [7:0] a);
        return c.flags[3] ? (a == 8'd0) : (a > c.a_thr);
    endfunction

    function automatic logic op_reserved(input logic [3:0] op);
        return op > MRG_AKEY;
    endfunction
endpackage

// File: rtl/pxa_slot_regs.sv
`timescale 1ns/1ps
module pxa_slot_regs
    import pxa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [HALF_W-1:0] cfg_data,
    input  logic              en_wr,
    input  logic [EN_W-1:0]   en_data,
    output logic [CW-1:0]     ctrl_word,
    output logic [CW-1:0]     mask_word,
    output logic [EN_W-1:0]   en_q
);
    // index 0 = control, 1 = mask
    logic [CW-1:0] word_q [2];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 2; k++) begin
                word_q[k] <= '0;
            end
            en_q <= '0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                if (cfg_wr && (cfg_sel[1] == k[0])) begin
                    if (cfg_sel[0]) begin
                        word_q[k][CW-1:HALF_W] <= cfg_data;
                    end else begin
                        word_q[k] <= {{HALF_W{1'b0}}, cfg_data};
                    end
                end
            end
            if (en_wr) begin
                en_q <= en_data;
            end
        end
    end

    assign ctrl_word = word_q[0];
    assign mask_word = word_q[1];
endmodule

// File: rtl/pxa_xform.sv
`timescale 1ns/1ps
module pxa_xform
    import pxa_pkg::*;
(
    input  attr_ctrl_t         ctrl,
    input  logic [PIX_W-1:0]   mask,
    input  logic [PIX_W-1:0]   src,
    input  logic [PIX_W-1:0]   old,
    input  logic               attr_on,
    output logic [PIX_W-1:0]   wr_data,
    output logic [LANES-1:0]   wr_be,
    output logic [1:0]         err
);
    logic [PIX_W-1:0] perm;
    logic             unused_fields;

    assign unused_fields = ^{ctrl.ext_rsv, ctrl.fmt_tag, ctrl.a_thr, ctrl.a_src, ctrl.flags};

    always_comb begin
        perm = src;
        if (attr_on && (ctrl.lane_perm == SWZ_REV || ctrl.lane_perm == SWZ_UNREV)) begin
            perm = reverse_lanes(src);
        end

        wr_data = perm;
        if (attr_on && ctrl.rd_merge) begin
            case (ctrl.mrg_op)
                MRG_MASK, MRG_AKEY: wr_data = (old & ~mask) | (perm & mask);
                MRG_XOR:            wr_data = old ^ perm;
                MRG_OR:             wr_data = old | perm;
                MRG_ADD:            wr_data = old + perm;
                MRG_SUB:            wr_data = old - perm;
                default:            wr_data = perm;
            endcase
        end

        wr_be = '1;
        if (attr_on && !ctrl.alpha_wr) begin
            wr_be[LANES-1] = 1'b0;
        end

        err = 2'b00;
        if (attr_on) begin
            err[0] = op_reserved(ctrl.mrg_op) || (ctrl.lane_perm == SWZ_RSV);
            err[1] = (ctrl.px_width != 2'd0);
        end
    end
endmodule

// File: rtl/pxa_store_attr.sv
`timescale 1ns/1ps
module pxa_store_attr
    import pxa_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [HALF_W-1:0] cfg_data,
    input  logic              en_wr,
    input  logic [EN_W-1:0]   en_data,
    output logic              ld_attr_en,
    output logic              ld_invert,
    input  logic              st_req,
    input  logic [AW-1:0]     st_addr,
    input  logic [PIX_W-1:0]  st_data,
    output logic              st_busy,
    output logic              st_done,
    output logic [1:0]        st_err,
    output logic              mem_rd_req,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic [PIX_W-1:0]  mem_rd_data,
    output logic              mem_wr_req,
    output logic [AW-1:0]     mem_wr_addr,
    output logic [PIX_W-1:0]  mem_wr_data,
    output logic [LANES-1:0]  mem_wr_be
);
    logic [CW-1:0]    ctrl_word;
    logic [CW-1:0]    mask_word;
    logic [EN_W-1:0]  en_q;
    attr_ctrl_t       live_ctrl;
    logic             live_pass;
    logic             accept;

    seq_e             state_q;
    logic [AW-1:0]    addr_q;
    logic [PIX_W-1:0] data_q;
    logic [PIX_W-1:0] mask_q;
    attr_ctrl_t       ctrl_q;
    logic             on_q;
    logic             pass_q;
    logic [1:0]       xf_err;

    pxa_slot_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_data  (cfg_data),
        .en_wr     (en_wr),
        .en_data   (en_data),
        .ctrl_word (ctrl_word),
        .mask_word (mask_word),
        .en_q      (en_q)
    );

    assign live_ctrl = attr_ctrl_t'(ctrl_word);
    assign live_pass = !en_q[EN_STORE] || alpha_pass(live_ctrl, st_data[PIX_W-1 -: 8]);
    assign accept    = st_req && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
            mask_q  <= '0;
            ctrl_q  <= '0;
            on_q    <= 1'b0;
            pass_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        addr_q  <= st_addr;
                        data_q  <= st_data;
                        mask_q  <= mask_word;
                        ctrl_q  <= live_ctrl;
                        on_q    <= en_q[EN_STORE];
                        pass_q  <= live_pass;
                        state_q <= (en_q[EN_STORE] && live_ctrl.rd_merge && live_pass)
                                   ? ST_READ : ST_WRITE;
                    end
                end
                ST_READ:  state_q <= ST_MERGE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    pxa_xform u_xform (
        .ctrl    (ctrl_q),
        .mask    (mask_q),
        .src     (data_q),
        .old     (mem_rd_data),
        .attr_on (on_q),
        .wr_data (mem_wr_data),
        .wr_be   (mem_wr_be),
        .err     (xf_err)
    );

    assign ld_attr_en  = en_q[EN_LOAD];
    assign ld_invert   = en_q[EN_LDINV];
    assign st_busy     = (state_q != ST_IDLE);
    assign st_done     = (state_q == ST_MERGE) || (state_q == ST_WRITE);
    assign st_err      = st_done ? xf_err : 2'b00;
    assign mem_rd_req  = (state_q == ST_READ);
    assign mem_rd_addr = addr_q;
    assign mem_wr_req  = st_done && pass_q;
    assign mem_wr_addr = addr_q;
endmodule

// File: rtl/pxa_chk.sv
`timescale 1ns/1ps
module pxa_chk (
    input logic clk,
    input logic rst,
    input logic st_req,
    input logic st_busy,
    input logic st_done,
    input logic mem_rd_req,
    input logic mem_wr_req
);
    // R12
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (st_req && !st_busy) |=> st_busy);

    // R12
    rd_then_done_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |=> st_done);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        st_done |=> !st_busy);

    // R5
    wr_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_req |-> st_done);

    // R12
    rd_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> (st_busy && !st_done));

    // R12
    one_access_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd_req, mem_wr_req}));
endmodule

bind pxa_store_attr pxa_chk u_pxa_chk (
    .clk        (clk),
    .rst        (rst),
    .st_req     (st_req),
    .st_busy    (st_busy),
    .st_done    (st_done),
    .mem_rd_req (mem_rd_req),
    .mem_wr_req (mem_wr_req)
);

// File: tb/test_pxa_store_attr.sv
`timescale 1ns/1ps
module test_pxa_store_attr;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [1:0]  cfg_sel;
    logic [15:0] cfg_data;
    logic        en_wr;
    logic [2:0]  en_data;
    logic        ld_attr_en, ld_invert;
    logic        st_req;
    logic [15:0] st_addr;
    logic [31:0] st_data;
    logic        st_busy, st_done;
    logic [1:0]  st_err;
    logic        mem_rd_req, mem_wr_req;
    logic [15:0] mem_rd_addr, mem_wr_addr;
    logic [31:0] mem_rd_data, mem_wr_data;
    logic [3:0]  mem_wr_be;

    int vectors = 0;
    int misses  = 0;
    int cyc     = 0;

    logic [31:0] mem [16];
    logic [31:0] m_ctrl = 32'h0;
    logic [31:0] m_mask = 32'h0;
    logic [2:0]  m_en   = 3'h0;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [1:0]  err;
    } exp_t;

    always #2.5 clk = ~clk;

    pxa_store_attr #(.AW(16)) i_pxa_store_attr (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .en_wr(en_wr), .en_data(en_data), .ld_attr_en(ld_attr_en), .ld_invert(ld_invert),
        .st_req(st_req), .st_addr(st_addr), .st_data(st_data), .st_busy(st_busy),
        .st_done(st_done), .st_err(st_err), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be)
    );

    // synchronous memory: read data one cycle after request
    always @(posedge clk) begin
        if (mem_rd_req) mem_rd_data <= mem[mem_rd_addr[3:0]];
        if (mem_wr_req) begin
            for (int b = 0; b < 4; b++) begin
                if (mem_wr_be[b]) mem[mem_wr_addr[3:0]][b*8 +: 8] <= mem_wr_data[b*8 +: 8];
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            misses = misses + 1;
            $display("FAIL watchdog: actual cycles=%0d expected completion", cyc);
            summary();
            $finish;
        end
    end

    function automatic exp_t model(input logic [31:0] c, input logic [31:0] m,
                                   input logic [31:0] s, input logic [31:0] o, input logic on);
        exp_t e;
        logic [7:0]  a;
        logic [31:0] p;
        logic        ok;
        a = s[31:24];
        if (!on) begin
            e.rd = 0; e.wr = 1; e.be = 4'hF; e.data = s; e.err = 2'b00;
            return e;
        end
        p  = (c[9:8] == 2'd1 || c[9:8] == 2'd2) ? {s[7:0], s[15:8], s[23:16], s[31:24]} : s;
        ok = c[3] ? (a == 8'd0) : (a > c[23:16]);
        e.rd  = ok && c[11];
        e.wr  = ok;
        e.be  = c[5] ? 4'hF : 4'h7;
        e.err = {c[7:6] != 2'd0, (c[15:12] > 4'd6) || (c[9:8] == 2'd3)};
        e.data = p;
        if (c[11]) begin
            case (c[15:12])
                4'd1, 4'd6: e.data = (o & ~m) | (p & m);
                4'd2:       e.data = o ^ p;
                4'd3:       e.data = o | p;
                4'd4:       e.data = o + p;
                4'd5:       e.data = o - p;
                default:    e.data = p;
            endcase
        end
        return e;
    endfunction

    task automatic cfg(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_sel = sel; cfg_data = d;
        @(negedge clk);
        cfg_wr = 0;
        case (sel)
            2'd0: m_ctrl = {16'h0, d};
            2'd1: m_ctrl = {d, m_ctrl[15:0]};
            2'd2: m_mask = {16'h0, d};
            default: m_mask = {d, m_mask[15:0]};
        endcase
    endtask

    task automatic set_en(input logic [2:0] d);
        @(negedge clk);
        en_wr = 1; en_data = d;
        @(negedge clk);
        en_wr = 0;
        m_en = d;
    endtask

    task automatic do_store(input logic [3:0] addr, input logic [31:0] d, input string req);
        exp_t e;
        logic rd_seen, wr_a;
        logic [3:0] be_a;
        logic [31:0] data_a, bm, dm_a, dm_e;
        logic [1:0] err_a;
        int lat, lat_e;
        @(negedge clk);
        e = model(m_ctrl, m_mask, d, mem[addr], m_en[0]);
        st_req = 1; st_addr = {12'h0, addr}; st_data = d;
        @(negedge clk);
        st_req = 0;
        rd_seen = mem_rd_req;
        lat = 1;
        if (!st_done) begin
            @(negedge clk);
            lat = 2;
        end
        wr_a = mem_wr_req; be_a = mem_wr_be; data_a = mem_wr_data; err_a = st_err;
        lat_e = e.rd ? 2 : 1;
        bm = {{8{e.be[3]}}, {8{e.be[2]}}, {8{e.be[1]}}, {8{e.be[0]}}};
        dm_a = e.wr ? (data_a & bm) : 32'h0;
        dm_e = e.wr ? (e.data & bm) : 32'h0;
        vectors = vectors + 1;
        if (!st_done || rd_seen !== e.rd || wr_a !== e.wr || lat != lat_e || err_a !== e.err
            || (e.wr && be_a !== e.be) || dm_a !== dm_e) begin
            misses = misses + 1;
            $display("FAIL %s: actual rd=%0b wr=%0b lat=%0d be=%h data=%h err=%b expected rd=%0b wr=%0b lat=%0d be=%h data=%h err=%b",
                     req, rd_seen, wr_a, lat, be_a, dm_a, err_a,
                     e.rd, e.wr, lat_e, e.be, dm_e, e.err);
        end
    endtask

    task automatic check(input logic cond, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors = vectors + 1;
        if (!cond) begin
            misses = misses + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) mem[i] = 32'h1357_9BDF + i * 32'h0F0F_1111;
        rst = 1; cfg_wr = 0; cfg_sel = 0; cfg_data = 0; en_wr = 0; en_data = 0;
        st_req = 0; st_addr = 0; st_data = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 R2 reset state
        check(!ld_attr_en && !ld_invert && !st_busy && !mem_wr_req && !mem_rd_req, "R1",
              {27'h0, ld_attr_en, ld_invert, st_busy, mem_wr_req, mem_rd_req}, 32'h0);
        // R1 zero control after reset: attributes off -> pass-through
        do_store(4'd0, 32'h0000_1234, "R1");

        // R2 load bits on outputs, store attributes still off
        set_en(3'b110);
        check(ld_attr_en && ld_invert, "R2", {30'h0, ld_attr_en, ld_invert}, 32'h3);
        // R3 pass-through with other control settings present
        cfg(2'd0, 16'hA3E8);
        do_store(4'd1, 32'h00AB_CDEF, "R3");

        set_en(3'b001);
        // R4 lane order codes
        cfg(2'd0, 16'h0120);
        do_store(4'd2, 32'h8811_2233, "R4");
        cfg(2'd0, 16'h0220);
        do_store(4'd3, 32'h4455_6677, "R4");
        cfg(2'd0, 16'h0320);
        do_store(4'd4, 32'h9900_AA55, "R4");

        // R1 high half keeps low; then low clears high
        cfg(2'd1, 16'h0080);
        // R5 boundary: alpha equal to threshold does not write
        do_store(4'd5, 32'h80FF_FFFF, "R5");
        do_store(4'd5, 32'h81FF_FFFF, "R5");
        cfg(2'd0, 16'h0020);
        do_store(4'd6, 32'h05C0_FFEE, "R1");
        do_store(4'd6, 32'h00C0_FFEE, "R5");

        // R6 inverted key
        cfg(2'd0, 16'h0028);
        do_store(4'd7, 32'h0012_3456, "R6");
        do_store(4'd7, 32'h0112_3456, "R6");

        // R7 alpha lane protection
        cfg(2'd0, 16'h0000);
        do_store(4'd8, 32'hFF44_5566, "R7");

        // R8 merge codes with mask 00FFFFFF (R1 mask halves)
        cfg(2'd2, 16'hFFFF);
        cfg(2'd3, 16'h00FF);
        for (int op = 0; op < 7; op++) begin
            cfg(2'd0, 16'h0820 | 16'(op << 12));
            do_store(4'(9 + op % 4), 32'hC0F0_0F3C + 32'(op), "R8");
        end
        // R8 alpha-key merge with zero alpha keeps old word
        cfg(2'd0, 16'h6820);
        do_store(4'd9, 32'h00FF_FFFF, "R8");

        // R9 merge op without read enable
        cfg(2'd0, 16'h2120);
        do_store(4'd10, 32'h7F01_0203, "R9");

        // R10 reserved merge codes
        cfg(2'd0, 16'h9820);
        do_store(4'd11, 32'h3322_1100, "R10");
        cfg(2'd0, 16'hF800);
        do_store(4'd12, 32'h3322_1100, "R10");

        // R11 unsupported width
        cfg(2'd0, 16'h0060);
        do_store(4'd13, 32'h7766_5544, "R11");
        cfg(2'd0, 16'h00A0);
        do_store(4'd14, 32'h7766_5544, "R11");

        // R12 request during busy is ignored
        cfg(2'd0, 16'h1820);
        @(negedge clk);
        st_req = 1; st_addr = 16'd15; st_data = 32'h4000_0001;
        @(negedge clk);
        check(st_busy && mem_rd_req, "R12", {30'h0, st_busy, mem_rd_req}, 32'h3);
        st_data = 32'h5000_0002;
        @(negedge clk);
        st_req = 0;
        check(st_done && mem_wr_req, "R12", {30'h0, st_done, mem_wr_req}, 32'h3);
        @(negedge clk);
        check(!st_busy && !mem_rd_req && !mem_wr_req, "R12",
              {29'h0, st_busy, mem_rd_req, mem_wr_req}, 32'h0);

        // R8 constrained random mix
        for (int n = 0; n < 200; n++) begin
            logic [31:0] d;
            logic [7:0]  a;
            if (n % 5 == 0) cfg(2'(2 + ($urandom % 2)), 16'($urandom));
            cfg(2'd1, 16'($urandom) & 16'h00FF);
            cfg(2'd0, 16'($urandom) & 16'h7FFF);
            if (n % 17 == 0) set_en({2'($urandom), ($urandom % 8) != 0});
            case ($urandom % 4)
                0: a = 8'h00;
                1: a = m_ctrl[23:16];
                2: a = m_ctrl[23:16] + 8'h01;
                default: a = 8'($urandom);
            endcase
            d = {a, 24'($urandom)};
            do_store(4'($urandom), d, "R8");
        end

        summary();
        $finish;
    end
endmodule